// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block is the digital half of a successive-approximation analog-to-digital converter. Software reaches it over a small byte-wide register bus with three addresses: a control/status byte, a primary result byte and a secondary result byte. The control byte holds a 4-bit analog channel number, a completion flag and two DAC output enables. The secondary byte also carries the conversion-width bit, which picks 10-bit or 8-bit operation.

Writing the control byte with the completion flag bit at 0 starts a conversion. The controller then runs a binary search, most significant bit first. On each cycle it drives a trial code to the external reference ladder and samples a one-bit comparator answer. When the search ends it loads the result, sets the completion flag and pulses an interrupt request. In 10-bit operation the primary result byte returns the top eight result bits. Once the secondary byte has been read, the primary byte returns the bottom eight bits until the next conversion completes. The comparator, the ladder and the input multiplexer are outside the block. They appear only as the `dac_code` output, the `cmp_in` input and the `chan_sel` output.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Control byte at address 0 has these fields. Bits 2:0 are the low channel bits and bit 4 is the high channel bit, so `chan_sel` = {bit4, bit2, bit1, bit0}. Bits 7:6 drive `dac_out_en[1:0]`. Bit 5 always reads 0.
- R2: A write to address 0 with bit 3 at 0 starts a conversion, and bit 3 then reads 0. A write with bit 3 at 1 starts nothing and leaves the flag unchanged. After reset the flag reads 1.
- R3: Bit 7 of address 2 is writable and selects the conversion width: 0 is 10-bit, 1 is 8-bit. The width is captured when a conversion starts, and a later write does not change the conversion already running.
- R4: 10-bit conversion: starting on the cycle after the start write, 10 trial cycles run from b9 down to b0. The `dac_code` output equals the accumulated code with the trial bit set, so the first trial is 512. A bit is kept when `cmp_in` is 1. One further cycle loads the result.
- R5: 8-bit conversion: 8 trial cycles run from b7 down to b0. With n the 8-bit trial value, `dac_code` = 4n−2, so the first trial is 510. One further cycle loads the result.
- R6: After a 10-bit conversion completes, address 1 returns result bits b9..b2 until address 2 is read.
- R7: Address 2 reads as {width bit, 00000, b9, b8}. Once address 2 has been read, address 1 returns b7..b0 until the next conversion completes.
- R8: After an 8-bit conversion, address 1 returns the full 8-bit result and address 2 bits 1:0 read 0.
- R9: During a conversion, addresses 1 and 2 return the previous conversion's result.
- R10: `irq` is high for exactly one cycle. That cycle is the first one in which the completion flag reads 1, which is 11 cycles (10-bit) or 9 cycles (8-bit) after the start write edge.
- R11: A start write during a conversion restarts the search from the MSB. No completion is signalled for the abandoned conversion.
- R12: After reset, `dac_code`, `irq`, `chan_sel` and `dac_out_en` are 0, the control byte reads 0x08, and both result bytes read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address (0 control, 1 primary result, 2 secondary result) |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; reading address 2 advances the byte order |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cmp_in | input | 1 | Comparator: 1 when the input is above the trial level |
| dac_code | output | 10 | Trial code to the reference ladder, 0 when idle |
| chan_sel | output | 4 | Analog channel number |
| dac_out_en | output | 2 | DAC output enables |
| irq | output | 1 | One-cycle conversion-complete request |

## Verification
A behavioural comparator answers `cmp_in` for a fixed input level. Levels of 0, 1, mid-scale values, values next to the 8-bit half-step boundaries (2 and 3) and full scale show whether the search is MSB-first and keeps bits correctly. They also show whether the 8-bit ladder code carries the half-step offset, and whether the top code saturates. Read sequences of primary-only, secondary-then-primary and reads during a conversion separate the MSB-aligned and LSB-aligned byte order, and show whether the previous result is held. A width change in the middle of a conversion, and a restart, show whether the width is captured at the start and whether a restart discards the earlier search.

// File: rtl/sar_adc_pkg.sv
// Package: shared register addresses, control byte bit positions and
// the search state encoding for the successive-approximation controller.
package sar_adc_pkg;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned CHAN_W = 4;
    localparam int unsigned DEN_W  = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_RES_A = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_RES_B = 2'd2;

    localparam int unsigned CTL_FLAG_BIT = 3;
    localparam int unsigned CTL_CHHI_BIT = 4;
    localparam int unsigned WIDTH_BIT    = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRIAL = 2'd1,
        ST_LOAD  = 2'd2
    } sar_state_t;
endpackage

// File: rtl/sar_ctrl_regs.sv
// Control/status and width registers.
// Holds the channel number, the DAC enables, the completion flag and the
// conversion-width bit. Decodes a start request from a control write.
// Assumes the bus strobes are single-cycle and synchronous to clk.
module sar_ctrl_regs
    import sar_adc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BUS_W-1:0]     wdata,
    input  logic                 conv_done,
    output logic                 start,
    output logic                 flag_q,
    output logic                 width8_q,
    output logic [CHAN_W-1:0]    chan_q,
    output logic [DEN_W-1:0]     den_q,
    output logic [BUS_W-1:0]     ctrl_byte
);
    logic ctrl_wr;

    // Decode a control write and a start request (flag bit written low).
    always_comb begin
        ctrl_wr = wr_en && (addr == ADR_CTRL);
        start   = ctrl_wr && !wdata[CTL_FLAG_BIT];
    end

    // Register updates: fields on control write, flag on start/completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q   <= '0;
            den_q    <= '0;
            flag_q   <= 1'b1;
            width8_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                chan_q <= {wdata[CTL_CHHI_BIT], wdata[2:0]};
                den_q  <= wdata[7:6];
            end
            if (start)
                flag_q <= 1'b0;
            else if (conv_done)
                flag_q <= 1'b1;
            if (wr_en && (addr == ADR_RES_B))
                width8_q <= wdata[WIDTH_BIT];
        end
    end

    // Assemble the readable control byte; bit 5 is unused and reads 0.
    always_comb begin
        ctrl_byte = {den_q, 1'b0, chan_q[3], flag_q, chan_q[2:0]};
    end

    AST_START_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !flag_q); // R2
endmodule

// File: rtl/sar_search_engine.sv
// Binary-search sequencer.
// On start it captures the width and clears the accumulator. It then tries
// one bit per cycle, MSB first, keeping the bit when cmp_in is 1, and
// spends one load cycle before returning idle. In narrow mode the ladder
// code is the trial shifted up with a half-step subtracted.
// Assumes FULL_W > NARROW_W and that cmp_in settles within one cycle.
module sar_search_engine
    import sar_adc_pkg::*;
#(
    parameter int unsigned FULL_W   = 10,
    parameter int unsigned NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              width8,
    input  logic              cmp_in,
    output logic [FULL_W-1:0] dac_code,
    output logic              done_pulse,
    output logic [FULL_W-1:0] result,
    output logic              result_w8
);
    localparam int unsigned IDX_W = $clog2(FULL_W);
    localparam int unsigned SHIFT = FULL_W - NARROW_W;
    localparam logic [FULL_W-1:0] HALF_STEP = FULL_W'(1) << (SHIFT - 1);

    sar_state_t        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [FULL_W-1:0] acc_q;
    logic              w8_q;
    logic [FULL_W-1:0] trial;

    // Form the trial code and the ladder output for the current bit.
    always_comb begin
        trial = acc_q | (FULL_W'(1) << idx_q);
        if (state_q != ST_TRIAL)
            dac_code = '0;
        else if (w8_q)
            dac_code = (trial << SHIFT) - HALF_STEP;
        else
            dac_code = trial;
    end

    // Completion is suppressed when a restart arrives in the load cycle.
    always_comb begin
        done_pulse = (state_q == ST_LOAD) && !start;
        result     = acc_q;
        result_w8  = w8_q;
    end

    // Search sequencing: restart on start, else step down one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            acc_q   <= '0;
            w8_q    <= 1'b0;
        end else if (start) begin
            state_q <= ST_TRIAL;
            idx_q   <= width8 ? IDX_W'(NARROW_W - 1) : IDX_W'(FULL_W - 1);
            acc_q   <= '0;
            w8_q    <= width8;
        end else begin
            case (state_q)
                ST_TRIAL: begin
                    if (cmp_in)
                        acc_q <= trial;
                    if (idx_q == '0)
                        state_q <= ST_LOAD;
                    else
                        idx_q <= idx_q - 1'b1;
                end
                ST_LOAD:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    AST_IDX_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIAL) && !start |=> (state_q == ST_LOAD) || (idx_q == $past(idx_q) - 1'b1)); // R4
    AST_KEPT_BITS_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIAL) && !start |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R4
endmodule

// File: rtl/sar_result_regs.sv
// Result storage and read-order sequencing.
// Captures the finished code only on completion. It tracks whether the
// secondary byte has been read since then, which switches the primary
// byte from the MSB-aligned to the LSB-aligned view.
// Assumes BUS_W < FULL_W <= 2*BUS_W - 1.
module sar_result_regs
    import sar_adc_pkg::*;
#(
    parameter int unsigned FULL_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_pulse,
    input  logic [FULL_W-1:0] result,
    input  logic              result_w8,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              width8,
    output logic [BUS_W-1:0]  res_a_byte,
    output logic [BUS_W-1:0]  res_b_byte
);
    localparam int unsigned HI_W  = FULL_W - BUS_W;
    localparam int unsigned PAD_W = BUS_W - 1 - HI_W;

    logic [FULL_W-1:0] full_q;
    logic              last_w8_q;
    logic              low_view_q;

    // Capture the result on completion; track the read order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q     <= '0;
            last_w8_q  <= 1'b0;
            low_view_q <= 1'b0;
        end else begin
            if (done_pulse) begin
                full_q     <= result;
                last_w8_q  <= result_w8;
                low_view_q <= 1'b0;
            end else if (rd_en && (addr == ADR_RES_B)) begin
                low_view_q <= 1'b1;
            end
        end
    end

    // Present the primary byte in the view that the read order selects.
    always_comb begin
        if (last_w8_q || low_view_q)
            res_a_byte = full_q[BUS_W-1:0];
        else
            res_a_byte = full_q[FULL_W-1:FULL_W-BUS_W];
        res_b_byte = {width8, {PAD_W{1'b0}}, full_q[FULL_W-1:BUS_W]};
    end

    AST_HOLD_PREVIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !done_pulse |=> $stable(full_q)); // R9
endmodule

// File: rtl/sar_adc_ctrl.sv
// Top level of the successive-approximation ADC controller.
// Connects the register file, the search engine and the result storage.
// Selects the read data by address and registers the interrupt pulse so
// that it coincides with the completion flag.
// Assumes a single bus master and an external comparator and ladder.
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int unsigned RES_W    = 10,
    parameter int unsigned NARROW_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic                 cmp_in,
    output logic [RES_W-1:0]     dac_code,
    output logic [3:0]           chan_sel,
    output logic [1:0]           dac_out_en,
    output logic                 irq
);
    logic              start;
    logic              flag_q;
    logic              width8_q;
    logic [BUS_W-1:0]  ctrl_byte;
    logic              done_pulse;
    logic [RES_W-1:0]  result;
    logic              result_w8;
    logic [BUS_W-1:0]  res_a_byte;
    logic [BUS_W-1:0]  res_b_byte;

    sar_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .conv_done (done_pulse),
        .start     (start),
        .flag_q    (flag_q),
        .width8_q  (width8_q),
        .chan_q    (chan_sel),
        .den_q     (dac_out_en),
        .ctrl_byte (ctrl_byte)
    );

    sar_search_engine #(.FULL_W(RES_W), .NARROW_W(NARROW_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .width8     (width8_q),
        .cmp_in     (cmp_in),
        .dac_code   (dac_code),
        .done_pulse (done_pulse),
        .result     (result),
        .result_w8  (result_w8)
    );

    sar_result_regs #(.FULL_W(RES_W)) u_result (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_pulse (done_pulse),
        .result     (result),
        .result_w8  (result_w8),
        .rd_en      (bus_rd),
        .addr       (bus_addr),
        .width8     (width8_q),
        .res_a_byte (res_a_byte),
        .res_b_byte (res_b_byte)
    );

    // Read data selection by address; unused address reads zero.
    always_comb begin
        case (bus_addr)
            ADR_CTRL:  bus_rdata = ctrl_byte;
            ADR_RES_A: bus_rdata = res_a_byte;
            ADR_RES_B: bus_rdata = res_b_byte;
            default:   bus_rdata = '0;
        endcase
    end

    // Interrupt request: one registered pulse per completed conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= done_pulse;
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R10
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q); // R10
endmodule

// File: tb/sar_adc_ctrl_tb.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [3:0] chan_sel;
    logic [1:0] dac_out_en;
    logic       irq;

    int vin = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 0;

    always #10 clk = ~clk;

    assign cmp_in = (vin > int'(dac_code));

    sar_adc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_in(cmp_in), .dac_code(dac_code), .chan_sel(chan_sel),
        .dac_out_en(dac_out_en), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_full, m_chan, m_den;
    bit m_flag, m_irq, m_mode, m_conv8, m_last8, m_low;

    function automatic int expect_code(int v, bit w8);
        int r;
        if (w8) begin
            r = (v + 1) / 4;
            if (r > 255) r = 255;
        end else begin
            r = (v == 0) ? 0 : v - 1;
            if (r > 1023) r = 1023;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        bit st;
        if (!rst_n) begin
            m_cnt = 0; m_full = 0; m_chan = 0; m_den = 0;
            m_flag = 1; m_irq = 0; m_mode = 0; m_conv8 = 0; m_last8 = 0; m_low = 0;
        end else begin
            st = bus_wr && bus_addr == 2'd0 && !bus_wdata[3];
            m_irq = 0;
            if (bus_rd && bus_addr == 2'd2) m_low = 1;
            if (m_cnt == 1 && !st) begin
                m_full = expect_code(vin, m_conv8);
                m_last8 = m_conv8; m_flag = 1; m_irq = 1; m_low = 0;
            end
            if (m_cnt > 0) m_cnt--;
            if (bus_wr && bus_addr == 2'd0) begin
                m_chan = {bus_wdata[4], bus_wdata[2:0]};
                m_den = bus_wdata[7:6];
            end
            if (st) begin
                m_cnt = (m_mode ? 8 : 10) + 1;
                m_conv8 = m_mode; m_flag = 0;
            end
            if (bus_wr && bus_addr == 2'd2) m_mode = bus_wdata[7];
            mon_on = 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison of every output against the model.
    always @(negedge clk) begin
        int er;
        if (mon_on && rst_n) begin
            case (bus_addr)
                2'd0: er = {m_den[1:0], 1'b0, m_chan[3], m_flag, m_chan[2:0]};
                2'd1: er = (m_last8 || m_low) ? (m_full & 255) : ((m_full >> 2) & 255);
                2'd2: er = {m_mode, 5'b0, m_full[9:8]};
                default: er = 0;
            endcase
            chk(bus_addr == 0 ? "R2 ctrl byte" : (bus_addr == 1 ? "R6 primary byte" : "R7 secondary byte"),
                bus_rdata, er);
            chk("R10 irq", irq, m_irq);
            chk("R1 chan_sel", chan_sel, m_chan);
            chk("R1 dac_out_en", dac_out_en, m_den);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic bus_read(input logic [1:0] a, output int v);
        @(posedge clk); #2;
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); v = bus_rdata;
        @(posedge clk); #2;
        bus_rd = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int v;
        int k;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R12 reset state
        @(negedge clk);
        chk("R12 dac_code after reset", dac_code, 0);
        chk("R12 irq after reset", irq, 0);
        chk("R12 chan_sel after reset", chan_sel, 0);
        bus_read(2'd0, v); chk("R12 ctrl byte after reset", v, 8'h08);
        bus_read(2'd1, v); chk("R12 primary byte after reset", v, 0);
        bus_read(2'd2, v); chk("R12 secondary byte after reset", v, 0);

        // R1 field layout, R2 write with flag bit high starts nothing
        bus_write(2'd0, 8'hFD);
        @(negedge clk);
        chk("R1 chan_sel field", chan_sel, 13);
        chk("R1 dac enables", dac_out_en, 3);
        chk("R2 no start when flag bit written 1", dac_code, 0);
        bus_read(2'd0, v); chk("R1 ctrl readback bit5 zero", v, 8'hDD);

        // R4 10-bit search, R6/R7 read ordering
        vin = 700;
        bus_write(2'd0, 8'h05);
        @(negedge clk); chk("R4 first trial code", dac_code, 512);
        @(negedge clk); chk("R4 second trial code", dac_code, 768);
        idle(12);
        bus_read(2'd1, v); chk("R6 upper byte", v, 699 >> 2);
        bus_read(2'd2, v); chk("R7 secondary byte", v, 2);
        bus_read(2'd1, v); chk("R7 low byte after secondary", v, 699 & 255);
        bus_read(2'd1, v); chk("R7 low view persists", v, 699 & 255);

        // R9 reads during a conversion return the previous result
        vin = 5;
        bus_write(2'd0, 8'h05);
        idle(3);
        bus_read(2'd1, v); chk("R9 primary during conversion", v, 699 & 255);
        bus_read(2'd2, v); chk("R9 secondary during conversion", v, 2);
        idle(12);
        bus_read(2'd1, v); chk("R6 upper byte small input", v, 4 >> 2);

        // R4 extremes
        vin = 0;
        bus_write(2'd0, 8'h00); idle(13);
        bus_read(2'd1, v); chk("R4 zero input", v, 0);
        vin = 1024;
        bus_write(2'd0, 8'h00); idle(13);
        bus_read(2'd1, v); chk("R4 full scale upper", v, 255);
        bus_read(2'd2, v); chk("R4 full scale secondary", v, 3);

        // R5/R8 8-bit mode
        bus_write(2'd2, 8'h80);
        vin = 500;
        bus_write(2'd0, 8'h00);
        @(negedge clk); chk("R5 first narrow trial", dac_code, 510);
        @(negedge clk); chk("R5 second narrow trial", dac_code, 254);
        idle(11);
        bus_read(2'd1, v); chk("R8 narrow result", v, 125);
        bus_read(2'd2, v); chk("R8 secondary in narrow mode", v, 8'h80);
        vin = 3;
        bus_write(2'd0, 8'h00); idle(11);
        bus_read(2'd1, v); chk("R5 half-step boundary above", v, 1);
        vin = 2;
        bus_write(2'd0, 8'h00); idle(11);
        bus_read(2'd1, v); chk("R5 half-step boundary at", v, 0);
        vin = 1024;
        bus_write(2'd0, 8'h00); idle(11);
        bus_read(2'd1, v); chk("R8 narrow full scale", v, 255);

        // R3 width captured at start
        vin = 700;
        bus_write(2'd0, 8'h00);
        idle(2);
        bus_write(2'd2, 8'h00);
        idle(11);
        bus_read(2'd1, v); chk("R3 width latched at start", v, 175);
        bus_read(2'd2, v); chk("R3 width bit now 10-bit", v, 0);

        // R11 restart
        vin = 300;
        bus_write(2'd0, 8'h00);
        idle(5);
        bus_write(2'd0, 8'h00);
        @(negedge clk); chk("R11 restart from MSB", dac_code, 512);
        k = 1;
        for (int i = 2; i <= 20; i++) begin
            @(negedge clk);
            if (irq) begin k = i; break; end
        end
        chk("R10 R11 irq cycle after restart", k, 12);
        idle(2);
        bus_read(2'd1, v); chk("R11 restarted result", v, 299 >> 2);

        idle(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule